// File: doc/BRIEF.md
# Shared Feature-Map Bank Controller

This block owns the bookkeeping for a pool of on-chip SRAM banks that two concurrent inference tasks share: a producer network that writes output feature maps and a consumer network that reads them. A role table gives each physical bank a role: free, weight, input or output. When a layer's output is complete, the output banks can be relabelled as input banks for the next layer without moving any data. Each bank keeps four status flags. A small state machine orders producer writes and consumer reads so that a bank holding unread output is never overwritten.

The state machine has four states. PH_FILL: the producer writes its output banks. In PH_FILL, the transition FILL->HANDOFF is taken when `prod_layer_done` arrives and every output bank is full. PH_HANDOFF lasts one cycle and pulses `read_start` to both tasks. From there the transition HANDOFF->FILL is taken when `layer_fits` is high: the output banks become input banks and both tasks read with no ordering between them. Otherwise the transition HANDOFF->HOLD is taken. PH_HOLD keeps the producer suspended until the consumer has read every output bank, and then takes HOLD->RELEASE. PH_RELEASE clears the output banks back to empty and takes RELEASE->FILL.

The status table is a mirror of every bank's flags. Shared banks (input or output role) are mirrored on the cycle after a change, together with an event pulse. Other banks are sampled by a periodic poll.

Top module: `sfm_bank_ctrl`

## Requirements
- R1: After reset every role is free (code 0), every status table entry reads 4'b0001, and `read_start`, `prod_suspend`, `cfg_err` and `status_irq` are low. Role codes: 0 free, 1 weight, 2 input, 3 output. Bank b's role is `role_map[2b+1:2b]`.
- R2: A configuration request that gives a non-free role to a bank that is not free is rejected. It raises `cfg_err` for one cycle and leaves the role unchanged. A request for a free bank, or any request for role free, is applied on the next clock edge with `cfg_err` low.
- R3: An applied configuration request resets that bank's flags to empty only. Flag layout: `status_tbl[4b+3:4b]` = {read-complete, write-complete, full, empty}.
- R4: A producer write is taken only in PH_FILL, only by an output bank, and only by a bank that is not full. A taken write clears empty. A taken write with `prod_wr_last` also sets full. Writes to banks of any other role leave their flags unchanged.
- R5: `prod_layer_done` in PH_FILL with every output bank full gives a `read_start` pulse exactly one cycle long, one edge later. At the end of that pulse every output bank gets write-complete set.
- R6: When `layer_fits` is high during the handoff, every output bank becomes an input bank and keeps its flags. `prod_suspend` stays low.
- R7: When `layer_fits` is low during the handoff, `prod_suspend` rises and stays high until every output bank has read-complete set. The output banks are then cleared to empty, keep their output role, and `prod_suspend` falls.
- R8: A consumer read report for a full bank with input or output role sets that bank's read-complete flag.
- R9: A flag change on a bank with input or output role appears in `status_tbl` one edge after the change, with a one-cycle `status_irq` pulse. A change on any other bank appears within POLL_DIV cycles and raises no pulse.
- R10: `prod_layer_done` while some output bank is not full is ignored: no `read_start` and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Role assignment request |
| cfg_bank | input | $clog2(NUM_BANKS) | Bank addressed by the request |
| cfg_role | input | 2 | Requested role code |
| cfg_err | output | 1 | Request rejected, bank already owned |
| layer_fits | input | 1 | Whole layer output fits on chip |
| prod_wr_valid | input | 1 | Producer write to a bank |
| prod_wr_bank | input | $clog2(NUM_BANKS) | Bank written |
| prod_wr_last | input | 1 | Write fills the bank |
| prod_layer_done | input | 1 | Producer finished the layer or part |
| cons_rd_valid | input | 1 | Consumer finished reading a bank |
| cons_rd_bank | input | $clog2(NUM_BANKS) | Bank read by the consumer |
| read_start | output | 1 | Both tasks may read the output maps |
| prod_suspend | output | 1 | Producer must stall |
| role_map | output | 2*NUM_BANKS | Current role of every bank |
| status_tbl | output | 4*NUM_BANKS | Mirrored flags of every bank |
| status_irq | output | 1 | Shared-bank status change event |

## Verification
The role table is exercised with a sequence of claims, re-claims and releases. Accepted and rejected requests alternate, so a missing ownership test and a wrong role update show up as different failures. The handoff is run twice: once with the layer fitting, which must relabel with no suspend, and once with the layer not fitting, where the suspend must outlast the first of two consumer reads and end only after the second. Writes to an input bank, and a premature layer-done, are checked to have no effect. A change on a released bank checks that the polled path updates the table without an event, which separates it from the event path.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    typedef enum logic [1:0] {
        ROLE_FREE = 2'd0,
        ROLE_WGT  = 2'd1,
        ROLE_IN   = 2'd2,
        ROLE_OUT  = 2'd3
    } role_t;

    typedef enum logic [1:0] {
        PH_FILL,
        PH_HANDOFF,
        PH_HOLD,
        PH_RELEASE
    } phase_t;

    typedef struct packed {
        logic rd_done;
        logic wr_done;
        logic full;
        logic empty;
    } bank_flags_t;

    localparam bank_flags_t FLAGS_EMPTY = 4'b0001;
endpackage

// File: rtl/sfm_role_table.sv
module sfm_role_table
    import sfm_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int IW = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [IW-1:0]        cfg_bank,
    input  role_t                cfg_role,
    input  logic                 relabel,
    output role_t                roles [NUM_BANKS],
    output logic [NUM_BANKS-1:0] cfg_hit,
    output logic                 cfg_err
);
    logic reject;

    assign reject = cfg_valid && (cfg_role != ROLE_FREE) && (roles[cfg_bank] != ROLE_FREE);

    always_comb begin
        cfg_hit = '0;
        if (cfg_valid && !reject) cfg_hit[cfg_bank] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) roles[b] <= ROLE_FREE;
        end else begin
            cfg_err <= reject;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cfg_hit[b])
                    roles[b] <= cfg_role;
                else if (relabel && roles[b] == ROLE_OUT)
                    roles[b] <= ROLE_IN;
            end
        end
    end

    // R2
    reject_keeps_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !relabel) |=> (roles[$past(cfg_bank)] == $past(roles[cfg_bank])));
endmodule

// File: rtl/sfm_bank_flags.sv
module sfm_bank_flags
    import sfm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr,
    input  logic        wr_last,
    input  logic        mark_wr_done,
    input  logic        rd,
    output bank_flags_t flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= FLAGS_EMPTY;
        end else if (clr) begin
            flags <= FLAGS_EMPTY;
        end else begin
            if (wr) begin
                flags.empty <= 1'b0;
                if (wr_last) flags.full <= 1'b1;
            end
            if (mark_wr_done) flags.wr_done <= 1'b1;
            if (rd) flags.rd_done <= 1'b1;
        end
    end

    // R3
    clear_to_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == FLAGS_EMPTY));

    // R4
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.full |-> !flags.empty);
endmodule

// File: rtl/sfm_status_table.sv
module sfm_status_table
    import sfm_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int POLL_DIV  = 16,
    localparam int CW = $clog2(POLL_DIV + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bank_flags_t            flags  [NUM_BANKS],
    input  logic [NUM_BANKS-1:0]   shared,
    output logic [4*NUM_BANKS-1:0] tbl,
    output logic                   irq
);
    logic [CW-1:0]        cnt;
    logic                 tick;
    logic [NUM_BANKS-1:0] chg;

    assign tick = (cnt == CW'(POLL_DIV - 1));

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            chg[b] = shared[b] && (flags[b] != tbl[4*b +: 4]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
            tbl <= {NUM_BANKS{FLAGS_EMPTY}};
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            irq <= |chg;
            for (int b = 0; b < NUM_BANKS; b++)
                if (tick || shared[b]) tbl[4*b +: 4] <= flags[b];
        end
    end
endmodule

// File: rtl/sfm_handoff_fsm.sv
module sfm_handoff_fsm
    import sfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic layer_done,
    input  logic layer_fits,
    input  logic all_out_full,
    input  logic all_out_rd,
    output logic fill_phase,
    output logic read_start,
    output logic mark_wr_done,
    output logic relabel,
    output logic release_clr,
    output logic suspend
);
    phase_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PH_FILL:    if (layer_done && all_out_full) nxt = PH_HANDOFF;
            PH_HANDOFF: nxt = layer_fits ? PH_FILL : PH_HOLD;
            PH_HOLD:    if (all_out_rd) nxt = PH_RELEASE;
            PH_RELEASE: nxt = PH_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_FILL;
        else        state <= nxt;
    end

    always_comb begin
        fill_phase   = 1'b0;
        read_start   = 1'b0;
        mark_wr_done = 1'b0;
        relabel      = 1'b0;
        release_clr  = 1'b0;
        suspend      = 1'b0;
        unique case (state)
            PH_FILL:    fill_phase = 1'b1;
            PH_HANDOFF: begin
                read_start   = 1'b1;
                mark_wr_done = 1'b1;
                relabel      = layer_fits;
            end
            PH_HOLD:    suspend = 1'b1;
            PH_RELEASE: release_clr = 1'b1;
        endcase
    end

    // R5
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_start |=> !read_start);

    // R7
    hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !all_out_rd) |=> suspend);

    // R10
    done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_phase && !all_out_full) |=> !read_start);
endmodule

// File: rtl/sfm_bank_ctrl.sv
module sfm_bank_ctrl
    import sfm_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int POLL_DIV  = 16,
    localparam int IW = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_valid,
    input  logic [IW-1:0]          cfg_bank,
    input  logic [1:0]             cfg_role,
    output logic                   cfg_err,
    input  logic                   layer_fits,
    input  logic                   prod_wr_valid,
    input  logic [IW-1:0]          prod_wr_bank,
    input  logic                   prod_wr_last,
    input  logic                   prod_layer_done,
    input  logic                   cons_rd_valid,
    input  logic [IW-1:0]          cons_rd_bank,
    output logic                   read_start,
    output logic                   prod_suspend,
    output logic [2*NUM_BANKS-1:0] role_map,
    output logic [4*NUM_BANKS-1:0] status_tbl,
    output logic                   status_irq
);
    role_t                roles [NUM_BANKS];
    bank_flags_t          flags [NUM_BANKS];
    logic [NUM_BANKS-1:0] cfg_hit, is_out, shared, out_ok, rd_ok;
    logic fill_phase, mark_wr_done, relabel, release_clr;
    logic all_out_full, all_out_rd;

    sfm_role_table #(.NUM_BANKS(NUM_BANKS)) u_roles (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_bank(cfg_bank),
        .cfg_role(role_t'(cfg_role)), .relabel(relabel), .roles(roles),
        .cfg_hit(cfg_hit), .cfg_err(cfg_err)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_take, rd_take;
        assign is_out[b] = (roles[b] == ROLE_OUT);
        assign shared[b] = is_out[b] || (roles[b] == ROLE_IN);
        assign out_ok[b] = !is_out[b] || flags[b].full;
        assign rd_ok[b]  = !is_out[b] || flags[b].rd_done;
        assign wr_take   = prod_wr_valid && (prod_wr_bank == IW'(b)) && fill_phase
                           && is_out[b] && !flags[b].full;
        assign rd_take   = cons_rd_valid && (cons_rd_bank == IW'(b)) && shared[b]
                           && flags[b].full;
        assign role_map[2*b +: 2] = roles[b];

        sfm_bank_flags u_flags (
            .clk(clk), .rst_n(rst_n),
            .clr(cfg_hit[b] || (release_clr && is_out[b])),
            .wr(wr_take), .wr_last(prod_wr_last),
            .mark_wr_done(mark_wr_done && is_out[b]),
            .rd(rd_take), .flags(flags[b])
        );
    end

    assign all_out_full = (&out_ok) && (|is_out);
    assign all_out_rd   = &rd_ok;

    sfm_handoff_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .layer_done(prod_layer_done), .layer_fits(layer_fits),
        .all_out_full(all_out_full), .all_out_rd(all_out_rd), .fill_phase(fill_phase),
        .read_start(read_start), .mark_wr_done(mark_wr_done), .relabel(relabel),
        .release_clr(release_clr), .suspend(prod_suspend)
    );

    sfm_status_table #(.NUM_BANKS(NUM_BANKS), .POLL_DIV(POLL_DIV)) u_status (
        .clk(clk), .rst_n(rst_n), .flags(flags), .shared(shared),
        .tbl(status_tbl), .irq(status_irq)
    );
endmodule

// File: tb/sfm_bank_ctrl_test.sv
module sfm_bank_ctrl_test;
    localparam int NB = 8;
    localparam int PD = 4;
    localparam int IW = $clog2(NB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 0, layer_fits = 0, prod_wr_valid = 0, prod_wr_last = 0;
    logic prod_layer_done = 0, cons_rd_valid = 0;
    logic [IW-1:0] cfg_bank = '0, prod_wr_bank = '0, cons_rd_bank = '0;
    logic [1:0] cfg_role = '0;
    logic cfg_err, read_start, prod_suspend, status_irq;
    logic [2*NB-1:0] role_map;
    logic [4*NB-1:0] status_tbl;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sfm_bank_ctrl #(.NUM_BANKS(NB), .POLL_DIV(PD)) uut (.*);

    // {bank[2:0], role[1:0], exp_err, exp_role[1:0]}
    localparam logic [7:0] VEC [7] = '{
        {3'd0, 2'd3, 1'b0, 2'd3},
        {3'd1, 2'd3, 1'b0, 2'd3},
        {3'd2, 2'd1, 1'b0, 2'd1},
        {3'd0, 2'd2, 1'b1, 2'd3},
        {3'd2, 2'd0, 1'b0, 2'd0},
        {3'd2, 2'd2, 1'b0, 2'd2},
        {3'd1, 2'd1, 1'b1, 2'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] role_of(input int b);
        return role_map[2*b +: 2];
    endfunction

    function automatic logic [3:0] tbl_of(input int b);
        return status_tbl[4*b +: 4];
    endfunction

    task automatic cfg(input int b, input logic [1:0] r);
        cfg_valid = 1; cfg_bank = IW'(b); cfg_role = r;
        cyc();
        cfg_valid = 0;
    endtask

    task automatic wr(input int b, input logic last);
        prod_wr_valid = 1; prod_wr_bank = IW'(b); prod_wr_last = last;
        cyc();
        prod_wr_valid = 0; prod_wr_last = 0;
    endtask

    task automatic rd(input int b);
        cons_rd_valid = 1; cons_rd_bank = IW'(b);
        cyc();
        cons_rd_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc();
        chk("R1 roles", role_map, '0);
        chk("R1 table", status_tbl, {NB{4'b0001}});
        chk("R1 outs", {read_start, prod_suspend, cfg_err, status_irq}, 4'b0);
        rst_n = 1;
        cyc();

        foreach (VEC[i]) begin
            cfg(int'(VEC[i][7:5]), VEC[i][4:3]);
            chk("R2 err", cfg_err, VEC[i][2]);
            chk("R2 role", role_of(int'(VEC[i][7:5])), VEC[i][1:0]);
        end

        wr(0, 1'b0);
        cyc();
        chk("R4 write clears empty", tbl_of(0), 4'b0000);
        chk("R9 irq on shared", status_irq, 1'b1);
        cyc();
        chk("R9 irq one cycle", status_irq, 1'b0);

        wr(2, 1'b1);
        cyc();
        chk("R4 input bank ignored", tbl_of(2), 4'b0001);

        wr(0, 1'b1);
        prod_layer_done = 1;
        cyc();
        prod_layer_done = 0;
        chk("R10 no start", read_start, 1'b0);
        chk("R4 last sets full", tbl_of(0), 4'b0010);

        wr(1, 1'b1);
        layer_fits = 1; prod_layer_done = 1;
        cyc();
        prod_layer_done = 0;
        chk("R5 start", read_start, 1'b1);
        chk("R6 no suspend", prod_suspend, 1'b0);
        cyc();
        chk("R5 pulse ends", read_start, 1'b0);
        chk("R6 relabel b0", role_of(0), 2'd2);
        chk("R6 relabel b1", role_of(1), 2'd2);
        cyc();
        chk("R5 wr_done kept", tbl_of(0), 4'b0110);

        rd(0);
        cyc();
        chk("R8 rd_done", tbl_of(0), 4'b1110);
        chk("R6 still no suspend", prod_suspend, 1'b0);

        cfg(3, 2'd3);
        cfg(4, 2'd3);
        wr(3, 1'b1);
        wr(4, 1'b1);
        layer_fits = 0; prod_layer_done = 1;
        cyc();
        prod_layer_done = 0;
        chk("R5 start partial", read_start, 1'b1);
        cyc();
        chk("R7 suspend", prod_suspend, 1'b1);
        rd(3);
        cyc();
        chk("R7 hold after one read", prod_suspend, 1'b1);
        rd(4);
        chk("R7 hold same edge", prod_suspend, 1'b1);
        cyc();
        chk("R7 released", prod_suspend, 1'b0);
        cyc();
        cyc();
        chk("R7 cleared", tbl_of(3), 4'b0001);
        chk("R7 role kept", role_of(3), 2'd3);

        cfg(0, 2'd0);
        for (int k = 0; k <= PD; k++) begin
            chk("R9 no irq on polled", status_irq, 1'b0);
            cyc();
        end
        chk("R3 reassigned flags empty", tbl_of(0), 4'b0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule